// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is a single output cell of a small programmable logic device in the 22V10 style. A vector of product-term results, already formed by an AND array elsewhere, is ORed into one sum term. Two configuration bits decide where the sum goes and how it reaches the pin. In registered mode the sum is captured in a D flip-flop on the rising clock edge. In combinational mode the sum goes straight through. In both modes the pin level can be true or inverted. A separate product term controls the pin's output enable. The cell returns a true and a complement feedback signal to the array.

The flip-flop is modelled as a two-state machine. The states are CLEAR (state 0) and SET (state 1). There are four transitions:
- LOAD moves to the sum value on a clock edge.
- PRESET moves to SET on a clock edge while the synchronous preset term is high.
- HOLD keeps the current state when the next value equals it.
- CLEAR_ASYNC forces CLEAR at once while the asynchronous reset term is high.

The reset and preset terms are shared by every registered cell of the device. They act on the flip-flop state, never directly on the pin level. The feedback source depends on the mode. In registered mode it is the flip-flop state. In combinational mode it is the sensed pin, taken after the tri-state buffer, so the cell can act as an input whenever its output is disabled.

Top module: `pld_out_cell`

## Requirements
- R1: The sum term is the OR of all `NUM_TERMS` bits of `pterm_in`. It is 1 when any bit is 1 and 0 when all bits are 0.
- R2: `pin_oe` equals `oe_term` in every mode and polarity.
- R3: With `cfg_comb`=0 (registered mode), each rising `clk` edge with `ar_term`=0 and `sp_term`=0 loads the sum into the state. `pin_drive` equals the state when `cfg_active_high`=1 and its inverse when `cfg_active_high`=0.
- R4: While `ar_term`=1 the state is CLEAR (0), without waiting for a clock edge. With active-low polarity the pin therefore shows 1.
- R5: When `sp_term`=1 and `ar_term`=0 at a rising `clk` edge, the state becomes SET (1) whatever the sum is.
- R6: When `ar_term` and `sp_term` are both 1, the state stays CLEAR.
- R7: In registered mode `fb_true` equals the state and `fb_comp` its inverse. Neither depends on `pin_sense` or on `oe_term`.
- R8: With `cfg_comb`=1 (combinational mode), `pin_drive` equals the sum when `cfg_active_high`=1 and its inverse when `cfg_active_high`=0, with no clock delay.
- R9: In combinational mode `fb_true` equals `pin_sense` and `fb_comp` equals its inverse. This includes an externally driven level while `pin_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for the flip-flop |
| pterm_in | input | NUM_TERMS | Logic product-term results from the AND array |
| oe_term | input | 1 | Output-enable product term |
| ar_term | input | 1 | Shared asynchronous reset term, active high |
| sp_term | input | 1 | Shared synchronous preset term, active high |
| cfg_comb | input | 1 | Mode bit: 1 combinational, 0 registered |
| cfg_active_high | input | 1 | Polarity bit: 1 true, 0 inverted |
| pin_sense | input | 1 | Level sensed at the pin, after the tri-state buffer |
| pin_drive | output | 1 | Value the output buffer drives |
| pin_oe | output | 1 | Output buffer enable |
| fb_true | output | 1 | True-form feedback to the array |
| fb_comp | output | 1 | Complement-form feedback to the array |

## Verification
The assertions take two things for granted about the inputs. First, `ar_term` is high from time zero until after the first clock edge, so the flip-flop never holds an unknown value at a sampled edge. Second, the configuration bits and the product-term inputs change only between clock edges. The bench drives every input on the falling edge. It holds the reset term through the first rising edge and models the pin as a resolved net, so `pin_sense` always reflects the driven value whenever the enable is high. Every combination of mode, polarity, enable, external level and product-term pattern is swept.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

    typedef enum logic [1:0] {
        SRC_REG_LOW   = 2'b00,
        SRC_REG_HIGH  = 2'b01,
        SRC_COMB_LOW  = 2'b10,
        SRC_COMB_HIGH = 2'b11
    } out_src_e;

    typedef enum logic {
        FF_CLEAR = 1'b0,
        FF_SET   = 1'b1
    } ff_state_e;

    typedef enum logic {
        FB_FROM_REG = 1'b0,
        FB_FROM_PIN = 1'b1
    } fb_src_e;

endpackage

// File: rtl/pld_sum_term.sv
module pld_sum_term #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] terms_in,
    output logic                 sum_out
);
    localparam int CHAIN_LEN = NUM_TERMS + 1;

    logic [CHAIN_LEN-1:0] chain;

    assign chain[0] = 1'b0;

    for (genvar gi = 0; gi < NUM_TERMS; gi++) begin : g_or
        assign chain[gi+1] = chain[gi] | terms_in[gi];
    end

    assign sum_out = chain[CHAIN_LEN-1];

endmodule

// File: rtl/pld_cell_reg.sv
module pld_cell_reg
    import pld_cell_pkg::*;
(
    input  logic      clk,
    input  logic      ar_in,
    input  logic      sp_in,
    input  logic      sum_in,
    output ff_state_e state_q
);
    ff_state_e state_d;

    // State register: asynchronous clear has priority over every edge.
    always_ff @(posedge clk or posedge ar_in) begin
        if (ar_in) begin
            state_q <= FF_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state process: PRESET, LOAD or HOLD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FF_CLEAR: begin
                if (sp_in || sum_in) begin
                    state_d = FF_SET;
                end
            end
            FF_SET: begin
                if (!sp_in && !sum_in) begin
                    state_d = FF_CLEAR;
                end
            end
        endcase
    end

    // R4 and R6: reset term seen at an edge means the state is already clear.
    p_ar_clears_r4: assert property (@(posedge clk)
        ar_in |-> state_q == FF_CLEAR);

    // R5: preset forces SET on the following edge.
    p_preset_sets_r5: assert property (@(posedge clk) disable iff (ar_in)
        sp_in |=> state_q == FF_SET);

    // R3: without preset the state follows the sum one edge later.
    p_load_sum_r3: assert property (@(posedge clk) disable iff (ar_in)
        !sp_in |=> (state_q == FF_SET) == $past(sum_in));

endmodule

// File: rtl/pld_out_mux.sv
module pld_out_mux
    import pld_cell_pkg::*;
(
    input  out_src_e  src_sel,
    input  ff_state_e state_in,
    input  logic      sum_in,
    output logic      drive_out
);
    always_comb begin
        drive_out = 1'b0;
        unique case (src_sel)
            SRC_REG_LOW:   drive_out = ~state_in;
            SRC_REG_HIGH:  drive_out = state_in;
            SRC_COMB_LOW:  drive_out = ~sum_in;
            SRC_COMB_HIGH: drive_out = sum_in;
        endcase
    end

endmodule

// File: rtl/pld_fb_mux.sv
module pld_fb_mux
    import pld_cell_pkg::*;
(
    input  fb_src_e   fb_sel,
    input  ff_state_e state_in,
    input  logic      pin_in,
    output logic      fb_true_out,
    output logic      fb_comp_out
);
    logic state_inv;

    // Registered feedback is taken from the inverted flip-flop output.
    assign state_inv = ~state_in;

    always_comb begin
        fb_comp_out = 1'b0;
        unique case (fb_sel)
            FB_FROM_REG: fb_comp_out = state_inv;
            FB_FROM_PIN: fb_comp_out = ~pin_in;
        endcase
        fb_true_out = ~fb_comp_out;
    end

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
    import pld_cell_pkg::*;
#(
    parameter int NUM_TERMS = 8
) (
    input  logic                 clk,
    input  logic [NUM_TERMS-1:0] pterm_in,
    input  logic                 oe_term,
    input  logic                 ar_term,
    input  logic                 sp_term,
    input  logic                 cfg_comb,
    input  logic                 cfg_active_high,
    input  logic                 pin_sense,
    output logic                 pin_drive,
    output logic                 pin_oe,
    output logic                 fb_true,
    output logic                 fb_comp
);
    logic      sum_w;
    ff_state_e state_w;
    out_src_e  src_sel;
    fb_src_e   fb_sel;

    assign src_sel = out_src_e'({cfg_comb, cfg_active_high});
    assign fb_sel  = fb_src_e'(cfg_comb);
    assign pin_oe  = oe_term;

    pld_sum_term #(.NUM_TERMS(NUM_TERMS)) u_sum (
        .terms_in (pterm_in),
        .sum_out  (sum_w)
    );

    pld_cell_reg u_reg (
        .clk     (clk),
        .ar_in   (ar_term),
        .sp_in   (sp_term),
        .sum_in  (sum_w),
        .state_q (state_w)
    );

    pld_out_mux u_omux (
        .src_sel   (src_sel),
        .state_in  (state_w),
        .sum_in    (sum_w),
        .drive_out (pin_drive)
    );

    pld_fb_mux u_fmux (
        .fb_sel      (fb_sel),
        .state_in    (state_w),
        .pin_in      (pin_sense),
        .fb_true_out (fb_true),
        .fb_comp_out (fb_comp)
    );

    // R7: registered pin and registered feedback come from the same state.
    p_reg_pin_matches_fb_r7: assert property (@(posedge clk) disable iff (ar_term)
        !cfg_comb |-> pin_drive == (cfg_active_high ? fb_true : !fb_true));

    // R9: combinational feedback follows the pin, not the driven value.
    p_comb_fb_from_pin_r9: assert property (@(posedge clk) disable iff (ar_term)
        cfg_comb |-> fb_true == pin_sense);

endmodule

// File: tb/pld_out_cell_test.sv
module pld_out_cell_test;
    localparam int NT = 8;
    localparam int PATTERNS = 1 << NT;
    localparam int WATCHDOG_CYCLES = 150000;

    logic          clk = 1'b0;
    logic [NT-1:0] pterm = '0;
    logic          oe = 1'b0;
    logic          ar = 1'b1;
    logic          sp = 1'b0;
    logic          comb = 1'b0;
    logic          high = 1'b0;
    logic          ext_val = 1'b0;
    logic          pin_sense;
    logic          pin_drive, pin_oe, fb_true, fb_comp;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    // Resolved pin: the driven value when enabled, else the external level.
    assign pin_sense = pin_oe ? pin_drive : ext_val;

    pld_out_cell #(.NUM_TERMS(NT)) uut (
        .clk             (clk),
        .pterm_in        (pterm),
        .oe_term         (oe),
        .ar_term         (ar),
        .sp_term         (sp),
        .cfg_comb        (comb),
        .cfg_active_high (high),
        .pin_sense       (pin_sense),
        .pin_drive       (pin_drive),
        .pin_oe          (pin_oe),
        .fb_true         (fb_true),
        .fb_comp         (fb_comp)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b pterm=%0h comb=%0b high=%0b oe=%0b ext=%0b",
                     req, act, exp, pterm, comb, high, oe, ext_val);
        end
    endtask

    // Registered-mode check of a known state value.
    task automatic chk_reg_state(input string req, input logic st);
        chk(req, fb_true, st);
        chk(req, fb_comp, ~st);
        chk(req, pin_drive, high ? st : ~st);
        chk("R2", pin_oe, oe);
    endtask

    initial begin
        // Reset state, R4: active-low registered cell shows 1 at the pin.
        #5;
        chk_reg_state("R4", 1'b0);
        @(negedge clk);
        chk_reg_state("R4", 1'b0);
        @(negedge clk);
        ar = 1'b0;

        // Combinational sweep: R1, R8, R9, R2.
        comb = 1'b1;
        for (int h = 0; h < 2; h++) begin
            for (int o = 0; o < 2; o++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int p = 0; p < PATTERNS; p++) begin
                        @(negedge clk);
                        high = h[0];
                        oe = o[0];
                        ext_val = e[0];
                        pterm = p[NT-1:0];
                        #2;
                        begin
                            logic s;
                            logic drv;
                            logic pin;
                            s = (p != 0);
                            drv = h[0] ? s : ~s;
                            pin = o[0] ? drv : e[0];
                            chk("R1/R8", pin_drive, drv);
                            chk("R2", pin_oe, o[0]);
                            chk("R9", fb_true, pin);
                            chk("R9", fb_comp, ~pin);
                        end
                    end
                end
            end
        end

        // Registered sweep: R3, R7 (external level must not reach feedback).
        @(negedge clk);
        comb = 1'b0;
        for (int h = 0; h < 2; h++) begin
            for (int o = 0; o < 2; o++) begin
                for (int p = 0; p < PATTERNS; p++) begin
                    @(negedge clk);
                    high = h[0];
                    oe = o[0];
                    pterm = p[NT-1:0];
                    ext_val = ~p[0];
                    @(posedge clk);
                    @(negedge clk);
                    chk_reg_state("R3/R7", p != 0);
                    ext_val = p[0];
                    #2;
                    chk("R7", fb_true, p != 0);
                end
            end
        end

        // R5: preset sets the state with the sum at zero.
        @(negedge clk);
        high = 1'b1;
        oe = 1'b1;
        pterm = '0;
        @(posedge clk);
        @(negedge clk);
        chk_reg_state("R5", 1'b0);
        sp = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_reg_state("R5", 1'b1);
        sp = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_reg_state("R3", 1'b0);

        // R4: asynchronous clear mid-cycle, before any edge.
        pterm = 8'h10;
        @(posedge clk);
        @(negedge clk);
        chk_reg_state("R3", 1'b1);
        high = 1'b0;
        #3;
        ar = 1'b1;
        #2;
        chk_reg_state("R4", 1'b0);
        chk("R4", pin_drive, 1'b1);

        // R6: reset and preset together keep the state clear.
        sp = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_reg_state("R6", 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk_reg_state("R6", 1'b0);
        ar = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_reg_state("R5", 1'b1);
        sp = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule